// File: doc/BRIEF.md
# Direct-Mapped Byte-Read Cache

This block holds recently used memory blocks for a requester that reads one byte at a time. It sits in front of a slower backing store, which always returns whole blocks. Every incoming address is cut into three fields. The low bits pick a byte inside a block, the middle bits pick exactly one cache line, and the high bits form the tag that tells apart the blocks sharing that line. A line answers the read only when its valid flag is set and its stored tag equals the address tag. The chosen byte is then steered out through a byte multiplexer.

When the line cannot answer, the requester stalls. The cache asks the backing store for the whole block, writes it into the indexed line, records the tag and sets the valid flag. The stalled read is then served from the freshly written line. There is no write path, and only one read is in flight at a time.

Top module: `dmc_byte_cache`

## Requirements
- R1: The byte select is address bits [OFS_W-1:0], the line index is bits [OFS_W+IDX_W-1:OFS_W] and the tag is all higher bits. With the defaults (4-bit address, 1 offset bit, 2 index bits, 1 tag bit), addresses 12 and 13 share line 2, and addresses 2 and 10 share line 1.
- R2: After reset every line is invalid, req_ready is 1, and both rsp_valid and mem_req are 0. The first read of any address therefore misses.
- R3: A read accepted (req_valid and req_ready at a clock edge) whose line is valid with a matching tag raises rsp_valid in the very next cycle. No memory request is made.
- R4: A read that misses raises mem_req in the cycle after acceptance. req_ready stays 0 while mem_req is high.
- R5: mem_req stays high, and mem_block_addr (the address with the byte-select bits removed) stays unchanged, until a cycle with mem_valid high.
- R6: The edge at which mem_valid is seen writes mem_data into the indexed line, stores the tag and sets the line valid. The next cycle raises rsp_valid with mem_req low. The stalled read is served from that line with exactly one block fetch.
- R7: Byte g of a block sits at mem_data[g*8 +: 8] and stays in byte g of the line. rsp_data is the byte selected by the address byte-select bits.
- R8: A refill overwrites whatever the line held before. From a cold cache, reading 0, 1, 13, 8, 0 gives miss, hit, miss, miss, miss, and alternating 2 and 10 misses every time.
- R9: Only one read is outstanding. req_ready is 0 from acceptance until the cycle after rsp_valid, rsp_valid lasts exactly one cycle, and requests presented while req_ready is 0 are not taken.
- R10: mem_valid while no refill is pending changes no line and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address of the read |
| req_ready | output | 1 | Cache idle and able to take a read |
| rsp_valid | output | 1 | One-cycle pulse: rsp_data holds the byte |
| rsp_data | output | DATA_W | Byte returned |
| mem_req | output | 1 | Block fetch requested |
| mem_block_addr | output | ADDR_W-OFS_W | Block address of the fetch |
| mem_valid | input | 1 | Fetched block present on mem_data |
| mem_data | input | DATA_W<<OFS_W | Whole fetched block, byte 0 in the low bits |

## Verification
On every cycle, the assertions check the handshake behaviour. Each accepted read leads to exactly one of an immediate response or a fetch. The fetch request holds with a stable block address until memory answers. A refill beat is followed directly by the response. The response is a single-cycle pulse that cannot overlap readiness, and a stray memory beat leaves the idle cache idle. Only the bench's scenarios can show which accesses hit or miss in the reference and conflict traces, that the returned byte is the right one of its block, and that a stray beat or an ignored busy-time request leaves line contents untouched.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_RESP = 2'd2
   } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
   parameter int ADDR_W = 4,
   parameter int IDX_W  = 2,
   parameter int OFS_W  = 1,
   localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [TAG_W-1:0]  tag,
   output logic [IDX_W-1:0]  idx,
   output logic [OFS_W-1:0]  ofs
);
   // low bits pick the byte, middle bits the line, the rest is the tag
   assign ofs = addr[OFS_W-1:0];
   assign idx = addr[OFS_W+IDX_W-1:OFS_W];
   assign tag = addr[ADDR_W-1:OFS_W+IDX_W];
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 1,
   parameter int LINE_W = 16,
   localparam int LINES = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [LINE_W-1:0] wr_data
);
   logic [LINES-1:0]  valid_q;
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [LINE_W-1:0] data_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/dmc_byte_sel.sv
module dmc_byte_sel #(
   parameter int DATA_W = 8,
   parameter int OFS_W  = 1,
   localparam int BYTES  = 1 << OFS_W,
   localparam int LINE_W = DATA_W * BYTES
) (
   input  logic [LINE_W-1:0] line,
   input  logic [OFS_W-1:0]  ofs,
   output logic [DATA_W-1:0] byte_out
);
   logic [DATA_W-1:0] lane [BYTES];

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      assign lane[g] = line[g*DATA_W +: DATA_W];
   end

   assign byte_out = lane[ofs];
endmodule

// File: rtl/dmc_byte_cache.sv
module dmc_byte_cache #(
   parameter int ADDR_W = 4,
   parameter int IDX_W  = 2,
   parameter int OFS_W  = 1,
   parameter int DATA_W = 8,
   localparam int TAG_W  = ADDR_W - IDX_W - OFS_W,
   localparam int LINE_W = DATA_W << OFS_W,
   localparam int BLK_W  = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              mem_req,
   output logic [BLK_W-1:0]  mem_block_addr,
   input  logic              mem_valid,
   input  logic [LINE_W-1:0] mem_data
);
   import dmc_pkg::*;

   if (IDX_W < 1 || OFS_W < 1) begin : g_bad_fields
      $error("dmc_byte_cache: index and byte-select fields need at least one bit");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("dmc_byte_cache: address too narrow to leave a tag");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dmc_byte_cache: DATA_W must be positive");
   end

   dmc_state_e        state_q, state_d;
   logic [ADDR_W-1:0] held_q;

   logic [TAG_W-1:0]  in_tag, held_tag, rd_tag;
   logic [IDX_W-1:0]  in_idx, held_idx, rd_idx;
   logic [OFS_W-1:0]  in_ofs, held_ofs;
   logic              rd_valid, lookup_hit, accept, fill_we;
   logic [LINE_W-1:0] rd_data;

   dmc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_split_in (
      .addr(req_addr), .tag(in_tag), .idx(in_idx), .ofs(in_ofs)
   );

   dmc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_split_held (
      .addr(held_q), .tag(held_tag), .idx(held_idx), .ofs(held_ofs)
   );

   // idle: look up the incoming address; busy: the held one
   assign rd_idx = (state_q == ST_IDLE) ? in_idx : held_idx;

   dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (rd_idx),
      .rd_valid(rd_valid),
      .rd_tag  (rd_tag),
      .rd_data (rd_data),
      .wr_en   (fill_we),
      .wr_idx  (held_idx),
      .wr_tag  (held_tag),
      .wr_data (mem_data)
   );

   dmc_byte_sel #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_sel (
      .line(rd_data), .ofs(held_ofs), .byte_out(rsp_data)
   );

   assign lookup_hit = rd_valid && (rd_tag == in_tag);
   assign accept     = req_valid && (state_q == ST_IDLE);
   assign fill_we    = (state_q == ST_FILL) && mem_valid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (accept) state_d = lookup_hit ? ST_RESP : ST_FILL;
         ST_FILL: if (mem_valid) state_d = ST_RESP;
         ST_RESP: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         held_q  <= '0;
      end else begin
         state_q <= state_d;
         if (accept) held_q <= req_addr;
      end
   end

   assign req_ready      = (state_q == ST_IDLE);
   assign rsp_valid      = (state_q == ST_RESP);
   assign mem_req        = (state_q == ST_FILL);
   assign mem_block_addr = held_q[ADDR_W-1:OFS_W];
endmodule

// File: rtl/dmc_byte_cache_chk.sv
module dmc_byte_cache_chk #(
   parameter int ADDR_W = 4,
   parameter int IDX_W  = 2,
   parameter int OFS_W  = 1,
   parameter int DATA_W = 8,
   localparam int LINE_W = DATA_W << OFS_W,
   localparam int BLK_W  = ADDR_W - OFS_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_data,
   input logic              mem_req,
   input logic [BLK_W-1:0]  mem_block_addr,
   input logic              mem_valid,
   input logic [LINE_W-1:0] mem_data
);
   AST_ACCEPT_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (rsp_valid != mem_req)); // R3
   AST_MISS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready); // R4
   AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_block_addr))); // R5
   AST_REFILL_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_valid) |=> (rsp_valid && !mem_req)); // R6
   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready)); // R9
   AST_RSP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready); // R9
   AST_STRAY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid && mem_valid) |=> (req_ready && !mem_req && !rsp_valid)); // R10
endmodule

bind dmc_byte_cache dmc_byte_cache_chk #(
   .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/dmc_byte_cache_tb.sv
module dmc_byte_cache_tb;
   localparam int ADDR_W = 4;
   localparam int OFS_W  = 1;
   localparam int DATA_W = 8;
   localparam int LINE_W = DATA_W << OFS_W;
   localparam int BLK_W  = ADDR_W - OFS_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_ready, rsp_valid, mem_req;
   logic [DATA_W-1:0] rsp_data;
   logic [BLK_W-1:0]  mem_block_addr;
   logic              mem_valid = 1'b0;
   logic [LINE_W-1:0] mem_data = '0;

   int checks = 0;
   int failures = 0;
   int fills = 0;
   int lat = 2;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   dmc_byte_cache u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .mem_req(mem_req), .mem_block_addr(mem_block_addr),
      .mem_valid(mem_valid), .mem_data(mem_data)
   );

   function automatic logic [7:0] mem_byte(input logic [3:0] a);
      return {a, ~a};
   endfunction

   function automatic logic [15:0] mem_block(input logic [2:0] b);
      return {mem_byte({b, 1'b1}), mem_byte({b, 1'b0})};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // backing memory: answers a pending fetch after lat cycles
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req && !mem_valid) begin
            repeat (lat) @(negedge clk);
            mem_data  = mem_block(mem_block_addr);
            mem_valid = 1'b1;
            fills++;
            @(negedge clk);
            mem_valid = 1'b0;
         end
      end
   end

   task automatic do_read(input logic [3:0] a, input bit exp_hit, input string req);
      int cyc;
      int f0;
      @(negedge clk);
      f0 = fills;
      req_valid = 1'b1;
      req_addr  = a;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      while (!rsp_valid && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
      if (exp_hit) begin
         check(cyc == 1 && fills == f0, req, $sformatf("hit addr %0d latency", a), cyc, 1);
      end else begin
         check(fills == f0 + 1, req, $sformatf("miss addr %0d fetch count", a), fills - f0, 1);
      end
      check(rsp_data == mem_byte(a), "R7", $sformatf("data addr %0d", a), rsp_data, mem_byte(a));
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(req_ready && !rsp_valid && !mem_req, "R2", "idle outputs after reset",
            {req_ready, rsp_valid, mem_req}, 3'b100);
   endtask

   task automatic t_reference_trace();
      do_read(4'd0,  1'b0, "R2");
      do_read(4'd1,  1'b1, "R3");
      do_read(4'd13, 1'b0, "R4");
      do_read(4'd8,  1'b0, "R8");
      do_read(4'd0,  1'b0, "R8");
   endtask

   task automatic t_conflict();
      // 2 and 10 both index line 1 (R1)
      do_read(4'd2,  1'b0, "R1");
      do_read(4'd10, 1'b0, "R8");
      do_read(4'd2,  1'b0, "R8");
      do_read(4'd10, 1'b0, "R8");
   endtask

   task automatic t_offsets();
      lat = 0;
      do_read(4'd3,  1'b0, "R6");
      do_read(4'd2,  1'b1, "R6");
      do_read(4'd12, 1'b1, "R1");
   endtask

   task automatic t_long_fetch();
      int f0;
      int rsp_seen;
      bit held_ok;
      lat = 6;
      f0 = fills;
      held_ok = 1'b1;
      rsp_seen = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 4'd5;
      @(posedge clk);
      @(negedge clk);
      req_addr = 4'd12;   // presented while busy, must not be taken
      for (int i = 0; i < 20; i++) begin
         if (rsp_valid) begin
            rsp_seen++;
            check(rsp_data == mem_byte(4'd5), "R6", "stalled read data", rsp_data, mem_byte(4'd5));
            req_valid = 1'b0;
         end else if (mem_req && !mem_valid) begin
            if (mem_block_addr != 3'd2 || req_ready) held_ok = 1'b0;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      check(held_ok, "R5", "fetch held with stable block address", held_ok, 1);
      check(rsp_seen == 1, "R9", "responses for one accepted read", rsp_seen, 1);
      check(fills == f0 + 1, "R9", "fetches while busy", fills - f0, 1);
      lat = 1;
      do_read(4'd4, 1'b1, "R6");
   endtask

   task automatic t_stray_beat();
      int f0;
      @(negedge clk);
      f0 = fills;
      mem_data  = 16'hA55A;
      mem_valid = 1'b1;
      @(negedge clk);
      mem_valid = 1'b0;
      check(req_ready && !rsp_valid && !mem_req, "R10", "state after stray beat",
            {req_ready, rsp_valid, mem_req}, 3'b100);
      do_read(4'd0, 1'b1, "R10");
      do_read(4'd1, 1'b1, "R10");
      check(fills == f0, "R10", "no fetch after stray beat", fills - f0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_reference_trace();
      t_conflict();
      t_offsets();
      t_long_fetch();
      t_stray_beat();
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule